// File: doc/BRIEF.md
# Flash Completion Polling Controller

This host-side controller waits for a parallel flash device to finish an internal program or erase operation. Once the command has gone out through other logic, a single `start` pulse hands the controller the completion method, the write polarity of the polled status bit and a poll budget. From then on it issues repeated read strobes, captures each returned word and judges completion from how the status bits behave. It ends with a one-cycle `done` pulse and the final valid word, or with a one-cycle `timeout` pulse and a sticky error flag.

There are three completion methods. Data polling compares status bit 7 with the expected value. After an erase, bit 7 reading 1 means the erase has finished. Toggle polling finishes when bit 6 holds still across two reads in a row. The third method samples an active-high ready line at each capture. Polling begins the cycle after the start pulse, with no wait in between.

Top module: `flash_done_poller`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `rd_strobe`, `done`, `timeout` and `err` are 0 and `final_data` is 0.
- R2: With `mode` = 0 (data polling) and `is_erase` = 0, a captured word is complete when its bit 7 equals `exp_poll_bit`. The controller then issues one more read and reports that word on `final_data` with `done`. The total read count is one more than the number of reads up to and including the first match.
- R3: With `mode` = 0 and `is_erase` = 1, a captured word is complete when its bit 7 is 1, whatever `exp_poll_bit` holds. One extra read follows, as in R2.
- R4: With `mode` = 1 (toggle polling), completion is declared when bit 6 of a captured word equals bit 6 of the word captured just before it in the same operation. The first read of an operation never completes. `final_data` is the latest word.
- R5: With `mode` = 2 (mode 3 behaves the same), a read is complete when `line_ready` is 1 at its capture edge. `final_data` is the word captured in that read.
- R6: Each read holds `rd_strobe` high for exactly STB_CYC consecutive cycles. `rdata` and `line_ready` are captured at the edge that ends the last strobe cycle. At least one low cycle separates two strobes.
- R7: If no completion is seen within max(`max_polls`,1) reads, the controller pulses `timeout` without `done` and raises `err`. `err` stays high until the next accepted `start`, which clears it.
- R8: A `start` pulse while `busy` is 1 is ignored. The running operation finishes with its original settings.
- R9: `done` and `timeout` are single-cycle pulses, never high together, and `busy` is 0 in the cycle either one is high.
- R10: `rd_strobe` and `busy` rise in the cycle after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| mode | input | 2 | 0 data polling, 1 toggle polling, 2/3 ready line |
| is_erase | input | 1 | Data polling after erase: complete on bit 7 = 1 |
| exp_poll_bit | input | 1 | Bit 7 of the data that was programmed |
| max_polls | input | CW | Poll budget (0 acts as 1) |
| rd_strobe | output | 1 | Read strobe to the flash, active high |
| rdata | input | DW | Data word returned by the flash |
| line_ready | input | 1 | Flash ready line, high when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle poll budget exhausted pulse |
| err | output | 1 | Sticky timeout error, cleared by start |
| final_data | output | DW | Final valid word read at completion |

## Verification
The assertions check on every cycle that `done` and `timeout` exclude each other and drop `busy`, that strobes only occur inside an operation, and that the latched settings stay fixed while busy. They also check that the poll count never passes its budget and that a toggle completion always has two reads behind it. The completion rules themselves, meaning which read counts as complete, the extra read after a data match and the word reported, can only be shown by the bench scenarios. There, a responder plays a flash that stays busy for a chosen number of reads. Capture timing is shown the same way: the responder presents a wrong word early in every strobe, so only a capture on the last strobe cycle sees the right one.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    MODE_DATA   = 2'd0,
    MODE_TOGGLE = 2'd1,
    MODE_LINE   = 2'd2,
    MODE_LINE2  = 2'd3
  } poll_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_FINAL = 2'd2
  } poll_state_e;

  localparam int unsigned DATA_POLL_BIT = 7;
  localparam int unsigned TOGGLE_BIT    = 6;
endpackage

// File: rtl/fpc_read_strobe.sv
module fpc_read_strobe #(
  parameter int unsigned DW      = 8,
  parameter int unsigned STB_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] rdata,
  input  logic          line_ready,
  output logic          strobe,
  output logic          cap_vld,
  output logic [DW-1:0] cap_data,
  output logic          cap_rdy
);
  localparam int unsigned SW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam logic [SW-1:0] LAST = SW'(STB_CYC - 1);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe   <= 1'b0;
      cnt      <= '0;
      cap_vld  <= 1'b0;
      cap_data <= '0;
      cap_rdy  <= 1'b0;
    end else begin
      cap_vld <= 1'b0;
      if (strobe) begin
        if (cnt == LAST) begin
          strobe   <= 1'b0;
          cap_vld  <= 1'b1;
          cap_data <= rdata;
          cap_rdy  <= line_ready;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (go) begin
        strobe <= 1'b1;
        cnt    <= '0;
      end
    end
  end

  // R6
  strobe_restart_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_vld |-> !strobe);
endmodule

// File: rtl/fpc_judge.sv
module fpc_judge (
  input  logic [1:0] mode,
  input  logic       erase,
  input  logic       exp_b7,
  input  logic       cur_b7,
  input  logic       cur_b6,
  input  logic       prev_b6,
  input  logic       have_prev,
  input  logic       rdy,
  output logic       complete
);
  import fpc_pkg::*;

  always_comb begin
    unique case (poll_mode_e'(mode))
      MODE_DATA:   complete = erase ? cur_b7 : (cur_b7 == exp_b7);
      MODE_TOGGLE: complete = have_prev && (cur_b6 == prev_b6);
      default:     complete = rdy;
    endcase
  end
endmodule

// File: rtl/fpc_poll_ctr.sv
module fpc_poll_ctr #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  logic [CW:0] next_cnt;

  assign next_cnt = {1'b0, count} + 1'b1;
  assign at_limit = next_cnt >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= next_cnt[CW-1:0];
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int unsigned DW      = 8,
  parameter int unsigned STB_CYC = 3,
  parameter int unsigned CW      = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          is_erase,
  input  logic          exp_poll_bit,
  input  logic [CW-1:0] max_polls,
  output logic          rd_strobe,
  input  logic [DW-1:0] rdata,
  input  logic          line_ready,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          err,
  output logic [DW-1:0] final_data
);
  import fpc_pkg::*;

  poll_state_e   state;
  poll_mode_e    mode_q;
  logic          erase_q, exp_q, prev_b6, have_prev;
  logic [CW-1:0] max_q, polls;
  logic          go, cap_vld, cap_rdy, complete, at_limit, accept;
  logic [DW-1:0] cap_data;

  assign accept = (state == ST_IDLE) && start;

  fpc_read_strobe #(.DW(DW), .STB_CYC(STB_CYC)) u_strobe (
    .clk(clk), .rst(rst), .go(go), .rdata(rdata), .line_ready(line_ready),
    .strobe(rd_strobe), .cap_vld(cap_vld), .cap_data(cap_data), .cap_rdy(cap_rdy)
  );

  fpc_judge u_judge (
    .mode(mode_q), .erase(erase_q), .exp_b7(exp_q),
    .cur_b7(cap_data[DATA_POLL_BIT]), .cur_b6(cap_data[TOGGLE_BIT]),
    .prev_b6(prev_b6), .have_prev(have_prev), .rdy(cap_rdy),
    .complete(complete)
  );

  fpc_poll_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .clr(accept), .inc((state == ST_POLL) && cap_vld),
    .limit(max_q), .count(polls), .at_limit(at_limit)
  );

  always_comb begin
    go = 1'b0;
    if (accept) go = 1'b1;
    else if (state == ST_POLL && cap_vld)
      go = complete ? (mode_q == MODE_DATA) : !at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mode_q     <= MODE_DATA;
      erase_q    <= 1'b0;
      exp_q      <= 1'b0;
      max_q      <= '0;
      prev_b6    <= 1'b0;
      have_prev  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      timeout    <= 1'b0;
      err        <= 1'b0;
      final_data <= '0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          mode_q    <= poll_mode_e'(mode);
          erase_q   <= is_erase;
          exp_q     <= exp_poll_bit;
          max_q     <= max_polls;
          have_prev <= 1'b0;
          err       <= 1'b0;
          busy      <= 1'b1;
          state     <= ST_POLL;
        end
        ST_POLL: if (cap_vld) begin
          prev_b6   <= cap_data[TOGGLE_BIT];
          have_prev <= 1'b1;
          if (complete) begin
            if (mode_q == MODE_DATA) begin
              state <= ST_FINAL;
            end else begin
              done       <= 1'b1;
              final_data <= cap_data;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end
          end else if (at_limit) begin
            timeout <= 1'b1;
            err     <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_FINAL: if (cap_vld) begin
          done       <= 1'b1;
          final_data <= cap_data;
          busy       <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_timeout_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));
  // R9
  end_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (done || timeout) |-> !busy);
  // R10
  first_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> rd_strobe);
  // R10
  strobe_in_op_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> busy);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(max_q) && $stable(erase_q)));
  // R7
  poll_limit_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (polls <= ((max_q == '0) ? CW'(1) : max_q)));
  // R4
  toggle_two_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == MODE_TOGGLE) |-> (polls >= CW'(2)));
endmodule

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;
  localparam int DW = 8, STB = 3, CW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, is_erase = 1'b0, exp_poll_bit = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [CW-1:0] max_polls = '0;
  logic rd_strobe, busy, done, timeout, err, line_ready = 1'b0;
  logic [DW-1:0] rdata = '0, final_data;

  flash_done_poller #(.DW(DW), .STB_CYC(STB), .CW(CW)) i_flash_done_poller (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .is_erase(is_erase),
    .exp_poll_bit(exp_poll_bit), .max_polls(max_polls), .rd_strobe(rd_strobe),
    .rdata(rdata), .line_ready(line_ready), .busy(busy), .done(done),
    .timeout(timeout), .err(err), .final_data(final_data)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int busy_cnt = 0, rd_idx = 0, cur_idx = 0, hi_run = 0, len_bad = 0;
  bit resp_erase = 1'b0, late = 1'b0;
  logic [DW-1:0] true_data = '0;
  int r_reads; bit r_done, r_to, r_err; logic [DW-1:0] r_final;

  function automatic logic [DW-1:0] word(int idx);
    if (idx < busy_cnt)
      return {(resp_erase ? 1'b0 : ~true_data[7]), idx[0], 6'h15};
    return true_data;
  endfunction

  // Flash responder: one word per strobe; optionally wrong until last strobe cycle
  always @(negedge clk) begin
    if (rd_strobe) begin
      hi_run++;
      if (hi_run == 1) begin
        cur_idx = rd_idx;
        rd_idx++;
        rdata = late ? (word(cur_idx) ^ 8'hC0) : word(cur_idx);
        line_ready = late ? 1'b0 : (cur_idx >= busy_cnt);
      end
      if (hi_run == STB) begin
        rdata = word(cur_idx);
        line_ready = (cur_idx >= busy_cnt);
      end
    end else begin
      if (hi_run != 0 && hi_run != STB) len_bad++;
      hi_run = 0;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] m, bit er, bit expb, int maxp, int bcnt, logic [DW-1:0] tdat);
    int w;
    busy_cnt = bcnt; true_data = tdat; resp_erase = er; rd_idx = 0;
    @(negedge clk);
    mode = m; is_erase = er; exp_poll_bit = expb; max_polls = CW'(maxp); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rd_strobe && busy, "R10 strobe+busy after start", {rd_strobe, busy}, 3);
    chk(!err, "R7 err cleared by start", err, 0);
    w = 0;
    while (!(done || timeout) && w < 20000) begin @(negedge clk); w++; end
    r_reads = rd_idx; r_done = done; r_to = timeout; r_final = final_data; r_err = err;
    chk(!busy && !(done && timeout), "R9 end pulse drops busy", {busy, done, timeout}, 0);
    @(negedge clk);
    chk(!done && !timeout, "R9 single-cycle pulse", {done, timeout}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !rd_strobe && !done && !timeout && !err && final_data == 0,
        "R1 reset state", {busy, rd_strobe, done, timeout, err}, 0);
  endtask

  task automatic t_data_prog(int bcnt, logic [DW-1:0] d);
    run_op(2'd0, 1'b0, d[7], 100, bcnt, d);
    chk(r_done && !r_to, "R2 data poll done", r_done, 1);
    chk(r_reads == bcnt + 2, "R2 match plus one extra read", r_reads, bcnt + 2);
    chk(r_final == d, "R2 final word", r_final, d);
  endtask

  task automatic t_data_erase(int bcnt);
    run_op(2'd0, 1'b1, 1'b0, 100, bcnt, 8'hFF);
    chk(r_done && r_reads == bcnt + 2, "R3 erase poll reads", r_reads, bcnt + 2);
    chk(r_final == 8'hFF, "R3 erase final word", r_final, 8'hFF);
  endtask

  task automatic t_toggle(int bcnt, logic [DW-1:0] d);
    int expn;
    if (bcnt == 0) expn = 2;
    else if (((bcnt - 1) & 1) == int'(d[6])) expn = bcnt + 1;
    else expn = bcnt + 2;
    run_op(2'd1, 1'b0, 1'b0, 100, bcnt, d);
    chk(r_done && r_reads == expn, "R4 toggle reads", r_reads, expn);
    chk(r_final == d, "R4 toggle final word", r_final, d);
  endtask

  task automatic t_line(logic [1:0] m, int bcnt, logic [DW-1:0] d);
    run_op(m, 1'b0, 1'b0, 100, bcnt, d);
    chk(r_done && r_reads == bcnt + 1, "R5 ready line reads", r_reads, bcnt + 1);
    chk(r_final == d, "R5 ready line final word", r_final, d);
  endtask

  task automatic t_timeout(int maxp);
    int lim;
    lim = (maxp == 0) ? 1 : maxp;
    run_op(2'd0, 1'b0, 1'b1, maxp, 1000, 8'h80);
    chk(r_to && !r_done && r_reads == lim, "R7 timeout after budget", r_reads, lim);
    chk(r_err, "R7 err raised", r_err, 1);
    repeat (5) @(negedge clk);
    chk(err && !done, "R7 err sticky", err, 1);
  endtask

  task automatic t_ignore_start;
    int w;
    busy_cnt = 4; true_data = 8'h66; resp_erase = 1'b0; rd_idx = 0;
    @(negedge clk);
    mode = 2'd0; is_erase = 1'b0; exp_poll_bit = 1'b0; max_polls = 100; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    mode = 2'd2; max_polls = 1; is_erase = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    while (!(done || timeout) && w < 20000) begin @(negedge clk); w++; end
    chk(done && rd_idx == 6 && final_data == 8'h66, "R8 start ignored while busy", rd_idx, 6);
    @(negedge clk);
  endtask

  task automatic t_late_capture;
    late = 1'b1;
    t_data_prog(2, 8'h4B);
    late = 1'b0;
    chk(len_bad == 0, "R6 strobe length and gap", len_bad, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_data_prog(3, 8'h5A);
    t_data_prog(0, 8'hA3);
    t_data_erase(4);
    t_toggle(5, 8'h3C);
    t_toggle(2, 8'h7E);
    t_toggle(3, 8'h7E);
    t_toggle(0, 8'h11);
    t_line(2'd2, 3, 8'hC9);
    t_line(2'd3, 0, 8'h24);
    t_timeout(5);
    t_timeout(0);
    t_ignore_start();
    t_late_capture();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule